// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the software-visible control face of one bus-master DMA channel for a disk-style storage interface. Software reaches it through a small byte-addressed I/O window. Each access is 1, 2 or 4 bytes wide and starts at any byte offset. The window holds three registers. The command register carries a run flag and a transfer direction. The status register reports channel activity, an error flag and an interrupt flag. The third register holds the base address of the descriptor table in memory.

On the hardware side the block drives the descriptor walker. It gives the walker a one-cycle launch pulse, the direction and the current table pointer. It takes back three inputs from the walker: a pointer-advance strobe, a completion strobe and an error strobe. The device interrupt is forwarded unchanged to the host, and its rising level is recorded in the status register.

The run flag acts only when it changes value. When it goes from 0 to 1, the table pointer is reloaded from the base register, and the walker is launched unless a transfer is already active. Clearing the run flag never stops a transfer that is under way: the transfer ends only when the walker reports completion.

Top module: `bmr_regs`

## Requirements
- R1: The command register at offset 0 keeps only bit 0 (run) and bit 3 (direction). Every other command bit reads back as 0. `walk_dir` shows bit 3.
- R2: Writing the run bit with the value it already holds has no effect. There is no `walk_go` pulse, and `walk_ptr` is not reloaded.
- R3: A write that changes run from 0 to 1 loads `walk_ptr` from the base register at that clock edge. If the channel is idle at that moment, `busy` is set at the same edge and `walk_go` is high for exactly the one following cycle. If the channel is already busy, the pointer is reloaded and no pulse is made.
- R4: A write that changes run from 1 to 0 leaves `busy` set.
- R5: The base register occupies bytes 4 to 7, little-endian. A write replaces only the byte lanes it covers. Bits 1:0 of the stored address are always 0.
- R6: A read returns the 8-byte window image shifted right by 8 times the offset and masked to the access width. Lanes past byte 7 read as 0. The size encoding is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.
- R7: `host_irq` equals `dev_irq` in the same cycle. A high `dev_irq` sets status bit 2 (interrupt) at the next edge. A low `dev_irq` leaves that bit unchanged.
- R8: Status sits at offset 2. Writing 1 to bit 1 (error) or to bit 2 (interrupt) clears that bit, and writing 0 leaves it alone. Bit 0 (active) cannot be written. `walk_err` sets bit 1. A set arriving in the same cycle as a clear wins.
- R9: `walk_done` clears `busy`, which is also status bit 0, at the next edge.
- R10: `ptr_step` adds 8 to `walk_ptr` at the next edge.
- R11: Reset clears the command, status, base and pointer, leaves `walk_go` low, and cancels any active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Register write strobe |
| acc_off | input | 3 | Byte offset in the window |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Write data, lane 0 at the offset |
| acc_rdata | output | 32 | Read data for offset and size |
| walk_go | output | 1 | One-cycle launch pulse to the walker |
| walk_dir | output | 1 | Transfer direction |
| walk_ptr | output | 32 | Current descriptor-table pointer |
| ptr_step | input | 1 | Advance pointer by one descriptor |
| walk_done | input | 1 | Transfer completed or cancelled |
| walk_err | input | 1 | Transfer error strobe |
| dev_irq | input | 1 | Device interrupt level |
| host_irq | output | 1 | Forwarded interrupt |
| busy | output | 1 | Transfer active |

## Verification
Reads are combinational, so a value is checked in the same cycle the offset and size are applied. Any register write, walker strobe or interrupt level takes effect at the next rising edge. `walk_go` is high for the one cycle after the edge that captured the rising run bit, and `host_irq` follows `dev_irq` with no delay. The bench applies every input just after a falling edge and samples at the following falling edge, one cycle later. Each expectation is therefore compared exactly one edge after its cause. The bench sweeps all base-write offsets and widths and all read offset and width pairs against an arithmetic model of the window.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int BUS_BYTES = 4;
  localparam int OFF_W     = 3;
  localparam int OFF_CMD   = 0;
  localparam int OFF_STAT  = 2;
  localparam int OFF_BASE  = 4;
  localparam int CMD_RUN   = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

  function automatic logic [BUS_BYTES-1:0] size_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: size_mask = 4'b0001;
      SZ_HALF: size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/bmr_lane_dec.sv
module bmr_lane_dec
  import bmr_pkg::*;
#(
  parameter int WIN_BYTES = 8
) (
  input  logic [OFF_W-1:0]       off,
  input  logic [1:0]             size,
  input  logic [8*BUS_BYTES-1:0] wdata,
  output logic [WIN_BYTES-1:0]   lane_en,
  output logic [8*WIN_BYTES-1:0] lane_data
);
  localparam int PAD_B = WIN_BYTES - BUS_BYTES;

  logic [WIN_BYTES-1:0]   en_ext;
  logic [8*WIN_BYTES-1:0] data_ext;

  always_comb begin
    en_ext    = {{PAD_B{1'b0}}, size_mask(size)};
    data_ext  = {{(8*PAD_B){1'b0}}, wdata};
    lane_en   = en_ext << off;
    lane_data = data_ext << {off, 3'b000};
  end
endmodule

// File: rtl/bmr_rd_sel.sv
module bmr_rd_sel
  import bmr_pkg::*;
#(
  parameter int WIN_BYTES = 8
) (
  input  logic [8*WIN_BYTES-1:0] image,
  input  logic [OFF_W-1:0]       off,
  input  logic [1:0]             size,
  output logic [8*BUS_BYTES-1:0] rdata
);
  logic [8*WIN_BYTES-1:0] shifted;
  logic [BUS_BYTES-1:0]   bmask;
  logic [8*BUS_BYTES-1:0] wmask;

  always_comb begin
    shifted = image >> {off, 3'b000};
    bmask   = size_mask(size);
  end

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_mask
    assign wmask[8*g +: 8] = {8{bmask[g]}};
  end

  assign rdata = shifted[8*BUS_BYTES-1:0] & wmask;
endmodule

// File: rtl/bmr_cmd_ctl.sv
module bmr_cmd_ctl
  import bmr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_wbyte,
  input  logic [ADDR_W-1:0] base,
  input  logic              ptr_step,
  input  logic              walk_done,
  output logic              run_q,
  output logic              dir_q,
  output logic              busy_q,
  output logic              go_q,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic              run_d, dir_d, busy_d, go_d;
  logic [ADDR_W-1:0] ptr_d;
  logic              run_rise, ctl_en;

  always_comb begin
    run_rise = cmd_we & cmd_wbyte[CMD_RUN] & ~run_q;
    go_d     = run_rise & ~busy_q;
    ctl_en   = cmd_we | ptr_step | walk_done;
    run_d    = run_q;
    dir_d    = dir_q;
    busy_d   = busy_q;
    ptr_d    = ptr_q;
    if (cmd_we) begin
      run_d = cmd_wbyte[CMD_RUN];
      dir_d = cmd_wbyte[CMD_DIR];
    end
    if (run_rise)      ptr_d = base;
    else if (ptr_step) ptr_d = ptr_q + STEP;
    if (go_d)           busy_d = 1'b1;
    else if (walk_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else if (ctl_en) begin
      run_q  <= run_d;
      dir_q  <= dir_d;
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else        go_q <= go_d;
  end
endmodule

// File: rtl/bmr_stat.sv
module bmr_stat
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_we,
  input  logic [7:0] stat_wbyte,
  input  logic       dev_irq,
  input  logic       walk_err,
  output logic       irq_q,
  output logic       err_q
);
  logic irq_d, err_d, clr_irq, clr_err, st_en;

  always_comb begin
    clr_irq = stat_we & stat_wbyte[ST_IRQ];
    clr_err = stat_we & stat_wbyte[ST_ERR];
    irq_d   = (irq_q & ~clr_irq) | dev_irq;
    err_d   = (err_q & ~clr_err) | walk_err;
    st_en   = stat_we | dev_irq | walk_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else if (st_en) begin
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/bmr_regs.sv
module bmr_regs
  import bmr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic [2:0]  acc_off,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        walk_go,
  output logic        walk_dir,
  output logic [31:0] walk_ptr,
  input  logic        ptr_step,
  input  logic        walk_done,
  input  logic        walk_err,
  input  logic        dev_irq,
  output logic        host_irq,
  output logic        busy
);
  localparam int BASE_B    = ADDR_W / 8;
  localparam int WIN_BYTES = OFF_BASE + BASE_B;

  logic [1:0]             rst_sync;
  logic                   rst_sync_n;
  logic [WIN_BYTES-1:0]   lane_en;
  logic [8*WIN_BYTES-1:0] lane_data;
  logic [ADDR_W-1:0]      base_q;
  logic                   run_q, dir_q, irq_flag, err_flag;
  logic [8*WIN_BYTES-1:0] image;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  bmr_lane_dec #(.WIN_BYTES(WIN_BYTES)) u_dec (
    .off(acc_off), .size(acc_size), .wdata(acc_wdata),
    .lane_en(lane_en), .lane_data(lane_data)
  );

  for (genvar g = 0; g < BASE_B; g++) begin : g_base
    logic       we_b;
    logic [7:0] d_b;
    assign we_b = acc_wr & lane_en[OFF_BASE+g];
    if (g == 0) begin : g_low
      assign d_b = {lane_data[8*OFF_BASE+2 +: 6], 2'b00};
    end else begin : g_hi
      assign d_b = lane_data[8*(OFF_BASE+g) +: 8];
    end
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)  base_q[8*g +: 8] <= 8'h00;
      else if (we_b)    base_q[8*g +: 8] <= d_b;
    end
  end

  bmr_cmd_ctl #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_we(acc_wr & lane_en[OFF_CMD]),
    .cmd_wbyte(lane_data[8*OFF_CMD +: 8]),
    .base(base_q), .ptr_step(ptr_step), .walk_done(walk_done),
    .run_q(run_q), .dir_q(dir_q), .busy_q(busy), .go_q(walk_go),
    .ptr_q(walk_ptr)
  );

  bmr_stat u_stat (
    .clk(clk), .rst_n(rst_sync_n),
    .stat_we(acc_wr & lane_en[OFF_STAT]),
    .stat_wbyte(lane_data[8*OFF_STAT +: 8]),
    .dev_irq(dev_irq), .walk_err(walk_err),
    .irq_q(irq_flag), .err_q(err_flag)
  );

  always_comb begin
    image = '0;
    image[8*OFF_CMD + CMD_RUN]  = run_q;
    image[8*OFF_CMD + CMD_DIR]  = dir_q;
    image[8*OFF_STAT + ST_ACT]  = busy;
    image[8*OFF_STAT + ST_ERR]  = err_flag;
    image[8*OFF_STAT + ST_IRQ]  = irq_flag;
    image[8*OFF_BASE +: ADDR_W] = base_q;
  end

  bmr_rd_sel #(.WIN_BYTES(WIN_BYTES)) u_rd (
    .image(image), .off(acc_off), .size(acc_size), .rdata(acc_rdata)
  );

  assign walk_dir = dir_q;
  assign host_irq = dev_irq;
endmodule

// File: rtl/bmr_regs_chk.sv
module bmr_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        walk_go,
  input logic        busy,
  input logic        walk_done,
  input logic [31:0] walk_ptr,
  input logic [31:0] base_q,
  input logic        dev_irq,
  input logic        irq_flag
);
  assert_go_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_go |-> busy);
  assert_go_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_go |-> walk_ptr == base_q);
  assert_go_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_go |=> !walk_go);
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_done) |=> busy);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && walk_done) |=> !busy);
  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq |=> irq_flag);
endmodule

bind bmr_regs bmr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .walk_go(walk_go), .busy(busy),
  .walk_done(walk_done), .walk_ptr(walk_ptr), .base_q(base_q),
  .dev_irq(dev_irq), .irq_flag(irq_flag)
);

// File: tb/bmr_regs_tb.sv
`timescale 1ns/1ps
module bmr_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_wr;
  logic [2:0]  acc_off;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        walk_go, walk_dir, host_irq, busy;
  logic [31:0] walk_ptr;
  logic        ptr_step, walk_done, walk_err, dev_irq;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_base, m_ptr;
  logic        m_run, m_dir, m_busy, m_irq, m_err, exp_go;

  always #2 clk = ~clk;

  bmr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_off(acc_off),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .walk_go(walk_go), .walk_dir(walk_dir), .walk_ptr(walk_ptr),
    .ptr_step(ptr_step), .walk_done(walk_done), .walk_err(walk_err),
    .dev_irq(dev_irq), .host_irq(host_irq), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    m_base = '0; m_ptr = '0; m_run = 0; m_dir = 0;
    m_busy = 0; m_irq = 0; m_err = 0; exp_go = 0;
  endtask

  function automatic logic [31:0] exp_rd(input int off, input int sz);
    logic [63:0] img, sh;
    logic [31:0] mask;
    img  = {m_base, 8'h00, 5'b0, m_irq, m_err, m_busy, 8'h00, 4'b0, m_dir, 2'b0, m_run};
    sh   = img >> (8 * off);
    mask = (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return sh[31:0] & mask;
  endfunction

  task automatic wr(input int off, input int sz, input logic [31:0] data);
    int n;
    @(negedge clk);
    acc_wr = 1; acc_off = 3'(off); acc_size = 2'(sz); acc_wdata = data;
    @(negedge clk);
    acc_wr = 0;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    exp_go = 0;
    for (int b = 0; b < 8; b++) begin
      int rel;
      logic [7:0] bt;
      rel = b - off;
      if (rel >= 0 && rel < n) begin
        bt = data[8*rel +: 8];
        if (b == 0) begin
          if (bt[0] && !m_run) begin
            m_ptr = m_base;
            if (!m_busy) begin m_busy = 1; exp_go = 1; end
          end
          m_run = bt[0]; m_dir = bt[3];
        end else if (b == 2) begin
          if (bt[1]) m_err = 0;
          if (bt[2]) m_irq = 0;
        end else if (b >= 4) begin
          m_base[8*(b-4) +: 8] = bt;
        end
      end
    end
    m_base[1:0] = 2'b00;
    chk("R3 go pulse", {31'b0, walk_go}, {31'b0, exp_go});
  endtask

  task automatic rd(input int off, input int sz, input string tag);
    acc_off = 3'(off); acc_size = 2'(sz);
    #1;
    chk(tag, acc_rdata, exp_rd(off, sz));
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    acc_wr = 0; acc_off = 0; acc_size = 0; acc_wdata = 0;
    ptr_step = 0; walk_done = 0; walk_err = 0; dev_irq = 0;
    model_clear();
    do_reset();

    // R11: reset state
    rd(0, 2, "R11 cmd/status after reset");
    rd(4, 2, "R11 base after reset");
    chk("R11 ptr", walk_ptr, 32'h0);
    chk("R11 busy/go", {30'b0, busy, walk_go}, 32'h0);

    // R5: base write sweep over every offset and width
    for (int off = 4; off < 8; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * (off * 4 + sz + 1);
        wr(off, sz, d);
        rd(4, 2, "R5 base lanes and alignment");
      end
    end
    wr(4, 2, 32'h1234_567B);
    rd(4, 2, "R5 low bits forced zero");

    // R1, R3: launch from idle with direction
    wr(0, 0, 32'h0000_00FF);
    rd(0, 0, "R1 command keeps bits 0 and 3");
    chk("R1 walk_dir", {31'b0, walk_dir}, 32'h1);
    chk("R3 ptr loaded", walk_ptr, m_base);
    chk("R3 busy set", {31'b0, busy}, 32'h1);
    @(negedge clk);
    chk("R3 go one cycle", {31'b0, walk_go}, 32'h0);

    // R10: pointer advance
    @(negedge clk); ptr_step = 1;
    @(negedge clk); @(negedge clk); ptr_step = 0;
    chk("R10 ptr step x2", walk_ptr, m_base + 32'd16);
    m_ptr = m_base + 32'd16;

    // R2: same run value again
    wr(0, 0, 32'h0000_0009);
    chk("R2 ptr not reloaded", walk_ptr, m_ptr);

    // R4: clear run while busy, then relaunch while busy
    wr(0, 0, 32'h0000_0000);
    chk("R4 busy held", {31'b0, busy}, 32'h1);
    wr(4, 2, 32'hCAFE_0100);
    wr(0, 0, 32'h0000_0001);
    chk("R3 reload while busy", walk_ptr, 32'hCAFE_0100);
    chk("R3 no go while busy", {31'b0, walk_go}, 32'h0);

    // R6: read sweep in a busy state
    for (int off = 0; off < 8; off++)
      for (int sz = 0; sz < 4; sz++)
        rd(off, sz, "R6 read sweep");

    // R9: completion
    walk_done = 1;
    @(negedge clk); walk_done = 0;
    m_busy = 0;
    chk("R9 busy cleared", {31'b0, busy}, 32'h0);
    rd(2, 0, "R9 active bit clear");

    // R7: interrupt forwarding and status
    dev_irq = 1; #1;
    chk("R7 host_irq same cycle", {31'b0, host_irq}, 32'h1);
    @(negedge clk); dev_irq = 0; m_irq = 1; #1;
    chk("R7 host_irq low", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    rd(2, 0, "R7 irq bit held after low level");

    // R8: error set, W1C, active read-only, set beats clear
    walk_err = 1;
    @(negedge clk); walk_err = 0; m_err = 1;
    rd(2, 0, "R8 error set");
    wr(2, 0, 32'h0000_0001);
    rd(2, 0, "R8 active bit read-only");
    wr(2, 0, 32'h0000_0002);
    rd(2, 0, "R8 error cleared");
    dev_irq = 1;
    wr(2, 0, 32'h0000_0004);
    dev_irq = 0; m_irq = 1;
    rd(2, 0, "R8 set wins over clear");
    wr(2, 0, 32'h0000_0004);
    rd(2, 0, "R8 irq cleared");

    // R11: reset in the middle of a transfer
    wr(0, 0, 32'h0000_0000);
    wr(0, 0, 32'h0000_0009);
    chk("R11 pre-reset busy", {31'b0, busy}, 32'h1);
    do_reset();
    chk("R11 busy cancelled", {31'b0, busy}, 32'h0);
    chk("R11 ptr cleared", walk_ptr, 32'h0);
    for (int off = 0; off < 8; off++)
      rd(off, 2, "R11 window cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule